// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block keeps four 32-bit event counters, PMC1 to PMC4, and two 32-bit mode words, mode A and mode B. Fields in the mode words choose what each counter adds whenever the update strobe is high. The core presents three per-strobe amounts with the strobe: elapsed processor cycles, completed loads and stores, and completed floating-point instructions. Every counter can count cycles. PMC2 can also count memory operations, and PMC3 can also count floating-point instructions.

Software loads the counters and the mode words through a single write port, and their current values are always visible on the outputs. The block raises an interrupt request when the top bit of a counter is set and that counter's enable is on. One enable covers PMC1 alone, and a second enable is shared by PMC2, PMC3 and PMC4. A separate flag reports that monitoring is configured, meaning that either mode word is nonzero.

Top module: `pmc_bank`

## Requirements
- R1: After reset all four counters and both mode words read zero, and `pmi_req` and `mon_active` are low.
- R2: A write with `wr_en` high stores `wr_data` at the next edge. Address 0 to 3 selects PMC1 to PMC4, address 4 selects mode A and address 5 selects mode B. A write to address 6 or 7 changes nothing.
- R3: A counter whose select code is 0 keeps its value on an update strobe.
- R4: With select code 1, a counter adds `cyc_cnt` on every strobe. This applies to all four counters.
- R5: With select code 11, PMC2 adds `ldst_cnt`.
- R6: With select code 11, PMC3 adds `fpi_cnt`.
- R7: A code that a counter does not recognise leaves it unchanged. This includes code 11 on PMC1 and PMC4, and code 2 on any counter.
- R8: The field layout is fixed. In mode A, bits [4:0] hold the PMC2 select, bits [10:5] hold the PMC1 select, bit 14 is the shared enable and bit 15 is the PMC1 enable. In mode B, bits [4:0] hold the PMC3 select and bits [9:5] hold the PMC4 select.
- R9: Counters wrap modulo 2^32.
- R10: `pmi_req` is high exactly when the PMC1 enable and bit 31 of PMC1 are both set, or when the shared enable is set and bit 31 of any of PMC2 to PMC4 is set. It stays high until one of those bits is cleared.
- R11: `mon_active` is high exactly when either mode word is nonzero.
- R12: A write to a counter in the same cycle as a strobe stores the written value instead of the sum, while the other counters still accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| upd_valid | input | 1 | Event update strobe |
| cyc_cnt | input | 32 | Cycles elapsed in this update |
| ldst_cnt | input | 32 | Loads and stores completed in this update |
| fpi_cnt | input | 32 | Floating-point instructions completed in this update |
| pmc_q | output | 128 | Counters; PMC(n+1) at bits [32n+31:32n] |
| mode_a_q | output | 32 | Mode word A |
| mode_b_q | output | 32 | Mode word B |
| pmi_req | output | 1 | Interrupt request |
| mon_active | output | 1 | Either mode word nonzero |

## Verification
Two situations are the hardest to reach from the ports. The first is a counter crossing into bit 31 or wrapping past zero through accumulation rather than through a write. The second is a counter write colliding with a strobe. The stimulus reaches the first by preloading counters just below 2^31 and just below 2^32 and then strobing them with cycle counts. It reaches the second by issuing a counter write in the same cycle as a strobe that moves every counter. The interrupt is then walked through each gating combination: enable off, shared enable on, top bit cleared, and the PMC1-only enable.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int NUM_PMC  = 4;
   localparam int ADDR_W   = 3;
   localparam int CODE_CYC = 1;
   localparam int CODE_ALT = 11;

   typedef enum logic [ADDR_W-1:0] {
      RA_PMC1  = 3'd0,
      RA_PMC2  = 3'd1,
      RA_PMC3  = 3'd2,
      RA_PMC4  = 3'd3,
      RA_MODEA = 3'd4,
      RA_MODEB = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/pmc_event_sel.sv
module pmc_event_sel #(
   parameter int SEL_W = 6,
   parameter int W     = 32
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             upd,
   input  logic [W-1:0]     cyc,
   input  logic [W-1:0]     alt,
   output logic             add_en,
   output logic [W-1:0]     inc
);
   import pmc_pkg::*;

   always_comb begin
      add_en = 1'b0;
      inc    = '0;
      if (upd) begin
         if (sel == SEL_W'(CODE_CYC)) begin
            add_en = 1'b1;
            inc    = cyc;
         end else if (sel == SEL_W'(CODE_ALT)) begin
            add_en = 1'b1;
            inc    = alt;
         end
      end
   end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic [W-1:0] wr_data,
   input  logic         add_en,
   input  logic [W-1:0] inc,
   output logic [W-1:0] value
);
   always_ff @(posedge clk) begin
      if (!rst_n)      value <= '0;
      else if (wr_hit) value <= wr_data;
      else if (add_en) value <= value + inc;
   end

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> value == $past(wr_data)); // R12
   AST_ACCUM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && add_en) |=> value == W'($past(value) + $past(inc))); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !add_en) |=> $stable(value)); // R3
endmodule

// File: rtl/pmc_irq_gen.sv
module pmc_irq_gen #(
   parameter int N = 4
) (
   input  logic [N-1:0] msb,
   input  logic         en_first,
   input  logic         en_rest,
   output logic         irq
);
   assign irq = (en_first && msb[0]) || (en_rest && (|msb[N-1:1]));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank #(
   parameter int W       = 32,
   parameter int SEL1_W  = 6,
   parameter int SEL_W   = 5,
   parameter int S1_LSB  = 5,
   parameter int S2_LSB  = 0,
   parameter int S3_LSB  = 0,
   parameter int S4_LSB  = 5,
   parameter int EN1_BIT = 15,
   parameter int ENX_BIT = 14
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [2:0]                    wr_addr,
   input  logic [W-1:0]                  wr_data,
   input  logic                          upd_valid,
   input  logic [W-1:0]                  cyc_cnt,
   input  logic [W-1:0]                  ldst_cnt,
   input  logic [W-1:0]                  fpi_cnt,
   output logic [pmc_pkg::NUM_PMC*W-1:0] pmc_q,
   output logic [W-1:0]                  mode_a_q,
   output logic [W-1:0]                  mode_b_q,
   output logic                          pmi_req,
   output logic                          mon_active
);
   import pmc_pkg::*;

   localparam int SEL_MAX = (SEL1_W > SEL_W) ? SEL1_W : SEL_W;

   if (W < 16) begin : g_bad_w
      $error("pmc_bank: W must be at least 16");
   end
   if (SEL_W < 4 || SEL1_W < 4) begin : g_bad_sel
      $error("pmc_bank: select fields must hold code 11");
   end
   if (S1_LSB + SEL1_W > W || S2_LSB + SEL_W > W || EN1_BIT >= W || ENX_BIT >= W) begin : g_bad_pos
      $error("pmc_bank: mode A field outside the word");
   end
   if (S3_LSB + SEL_W > W || S4_LSB + SEL_W > W) begin : g_bad_posb
      $error("pmc_bank: mode B field outside the word");
   end

   logic [NUM_PMC-1:0] msb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_a_q <= '0;
         mode_b_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == RA_MODEA) mode_a_q <= wr_data;
         if (wr_addr == RA_MODEB) mode_b_q <= wr_data;
      end
   end

   for (genvar gi = 0; gi < NUM_PMC; gi++) begin : g_pmc
      logic [SEL_MAX-1:0] sel;
      logic [W-1:0]       alt;
      logic               add_en;
      logic [W-1:0]       inc;
      logic [W-1:0]       value;
      logic               hit;

      if (gi == 0) begin : g_c1
         assign sel = SEL_MAX'(mode_a_q[S1_LSB +: SEL1_W]);
         assign alt = '0;
      end else if (gi == 1) begin : g_c2
         assign sel = SEL_MAX'(mode_a_q[S2_LSB +: SEL_W]);
         assign alt = ldst_cnt;
      end else if (gi == 2) begin : g_c3
         assign sel = SEL_MAX'(mode_b_q[S3_LSB +: SEL_W]);
         assign alt = fpi_cnt;
      end else begin : g_c4
         assign sel = SEL_MAX'(mode_b_q[S4_LSB +: SEL_W]);
         assign alt = '0;
      end

      assign hit = wr_en && (wr_addr == ADDR_W'(gi));

      pmc_event_sel #(.SEL_W(SEL_MAX), .W(W)) u_sel (
         .sel    (sel),
         .upd    (upd_valid),
         .cyc    (cyc_cnt),
         .alt    (alt),
         .add_en (add_en),
         .inc    (inc)
      );

      pmc_counter #(.W(W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (hit),
         .wr_data (wr_data),
         .add_en  (add_en),
         .inc     (inc),
         .value   (value)
      );

      assign pmc_q[gi*W +: W] = value;
      assign msb[gi]          = value[W-1];
   end

   pmc_irq_gen #(.N(NUM_PMC)) u_irq (
      .msb      (msb),
      .en_first (mode_a_q[EN1_BIT]),
      .en_rest  (mode_a_q[ENX_BIT]),
      .irq      (pmi_req)
   );

   assign mon_active = (|mode_a_q) || (|mode_b_q);

   AST_IRQ_NEEDS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      pmi_req |-> (|msb)); // R10
   AST_IRQ_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_MODEA && !wr_data[EN1_BIT] && !wr_data[ENX_BIT]) |=> !pmi_req); // R10
   AST_ACTIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_MODEA && wr_data != '0) |=> mon_active); // R11
   AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > RA_MODEB && !upd_valid) |=> $stable(pmc_q) && $stable(mode_a_q) && $stable(mode_b_q)); // R2
endmodule

// File: tb/tb_pmc_bank.sv
`timescale 1ns/1ps
module tb_pmc_bank;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         upd_valid = 1'b0;
   logic [31:0]  cyc_cnt = '0, ldst_cnt = '0, fpi_cnt = '0;
   logic [127:0] pmc_q;
   logic [31:0]  mode_a_q, mode_b_q;
   logic         pmi_req, mon_active;

   int checks = 0;
   int failures = 0;

   typedef struct {
      string       tag;
      logic [31:0] pmc [4];
      logic [31:0] ma, mb;
      logic        irq, act;
   } exp_t;

   exp_t sb[$];
   logic [31:0] m_pmc [4];
   logic [31:0] m_a, m_b;

   always #4 clk = ~clk;

   pmc_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .upd_valid(upd_valid), .cyc_cnt(cyc_cnt), .ldst_cnt(ldst_cnt), .fpi_cnt(fpi_cnt),
      .pmc_q(pmc_q), .mode_a_q(mode_a_q), .mode_b_q(mode_b_q),
      .pmi_req(pmi_req), .mon_active(mon_active)
   );

   // R8 layout: A[4:0]=PMC2 sel, A[10:5]=PMC1 sel, A[14]=shared en, A[15]=PMC1 en
   function automatic logic [31:0] mk_a(bit en1, bit enx, int s1, int s2);
      return (32'(en1) << 15) | (32'(enx) << 14) | ((32'(s1) & 32'h3f) << 5) | (32'(s2) & 32'h1f);
   endfunction
   // R8 layout: B[4:0]=PMC3 sel, B[9:5]=PMC4 sel
   function automatic logic [31:0] mk_b(int s3, int s4);
      return ((32'(s4) & 32'h1f) << 5) | (32'(s3) & 32'h1f);
   endfunction

   function automatic logic [31:0] amount(int idx, logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c, logic [31:0] l, logic [31:0] f);
      int code;
      case (idx)
         0: code = int'(a[10:5]);
         1: code = int'(a[4:0]);
         2: code = int'(b[4:0]);
         default: code = int'(b[9:5]);
      endcase
      if (code == 1) return c;
      if (idx == 1 && code == 11) return l;
      if (idx == 2 && code == 11) return f;
      return 32'd0;
   endfunction

   task automatic step(bit we, int a, logic [31:0] d, bit up,
                       logic [31:0] c, logic [31:0] l, logic [31:0] f, string tag);
      exp_t e;
      logic [31:0] na [4];
      @(negedge clk);
      wr_en = we; wr_addr = 3'(a); wr_data = d;
      upd_valid = up; cyc_cnt = c; ldst_cnt = l; fpi_cnt = f;
      for (int i = 0; i < 4; i++) begin
         na[i] = m_pmc[i];
         if (up) na[i] = m_pmc[i] + amount(i, m_a, m_b, c, l, f);
         if (we && a == i) na[i] = d;
      end
      if (we && a == 4) m_a = d;
      if (we && a == 5) m_b = d;
      for (int i = 0; i < 4; i++) m_pmc[i] = na[i];
      e.tag = tag;
      for (int i = 0; i < 4; i++) e.pmc[i] = m_pmc[i];
      e.ma = m_a; e.mb = m_b;
      e.irq = (m_a[15] && m_pmc[0][31]) || (m_a[14] && (m_pmc[1][31] || m_pmc[2][31] || m_pmc[3][31]));
      e.act = (m_a != 0) || (m_b != 0);
      sb.push_back(e);
   endtask

   task automatic wr(int a, logic [31:0] d, string tag);
      step(1'b1, a, d, 1'b0, 0, 0, 0, tag);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            for (int i = 0; i < 4; i++) begin
               checks++;
               if (pmc_q[i*32 +: 32] !== e.pmc[i]) begin
                  failures++;
                  $display("FAIL %s PMC%0d actual=%h expected=%h", e.tag, i + 1, pmc_q[i*32 +: 32], e.pmc[i]);
               end
            end
            checks++;
            if (mode_a_q !== e.ma || mode_b_q !== e.mb) begin
               failures++;
               $display("FAIL %s mode actual=%h/%h expected=%h/%h", e.tag, mode_a_q, mode_b_q, e.ma, e.mb);
            end
            checks++;
            if (pmi_req !== e.irq) begin
               failures++;
               $display("FAIL %s pmi_req actual=%b expected=%b", e.tag, pmi_req, e.irq);
            end
            checks++;
            if (mon_active !== e.act) begin
               failures++;
               $display("FAIL %s mon_active actual=%b expected=%b", e.tag, mon_active, e.act);
            end
         end
      end
   end

   initial begin : watchdog
      #(8 * 20000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 4; i++) m_pmc[i] = '0;
      m_a = '0; m_b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (pmc_q !== '0 || mode_a_q !== '0 || mode_b_q !== '0 || pmi_req !== 1'b0 || mon_active !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset actual=%h/%h/%h/%b/%b expected=0", pmc_q, mode_a_q, mode_b_q, pmi_req, mon_active);
      end
      // R2 write and readback
      wr(0, 32'h0000_0100, "R2");
      wr(1, 32'h0000_0200, "R2");
      wr(2, 32'h0000_0300, "R2");
      wr(3, 32'h0000_0400, "R2");
      wr(6, 32'hFFFF_FFFF, "R2");
      wr(7, 32'h1234_5678, "R2");
      // R4 cycles on all four, R11 active
      wr(4, mk_a(0, 0, 1, 1), "R11");
      wr(5, mk_b(1, 1), "R8");
      step(0, 0, 0, 1, 32'd5, 32'd70, 32'd90, "R4");
      step(0, 0, 0, 1, 32'd6, 32'd0, 32'd0, "R4");
      // R5 R6 R7 alternate code
      wr(4, mk_a(0, 0, 11, 11), "R5");
      wr(5, mk_b(11, 11), "R6");
      step(0, 0, 0, 1, 32'd7, 32'd3, 32'd9, "R5");
      step(0, 0, 0, 1, 32'd1, 32'd4, 32'd8, "R6");
      // R7 code 2 everywhere
      wr(4, mk_a(0, 0, 2, 2), "R7");
      wr(5, mk_b(2, 2), "R7");
      step(0, 0, 0, 1, 32'd11, 32'd12, 32'd13, "R7");
      // R3 code 0
      wr(4, mk_a(0, 0, 0, 0), "R3");
      wr(5, mk_b(0, 0), "R3");
      step(0, 0, 0, 1, 32'd11, 32'd12, 32'd13, "R3");
      // R9 wrap
      wr(0, 32'hFFFF_FFF0, "R9");
      wr(4, mk_a(0, 0, 1, 1), "R9");
      wr(1, 32'h7FFF_FFFF, "R9");
      step(0, 0, 0, 1, 32'h20, 0, 0, "R9");
      // R10 gating
      wr(4, mk_a(0, 1, 1, 1), "R10");
      wr(1, 32'd0, "R10");
      wr(3, 32'h8000_0000, "R10");
      wr(4, mk_a(0, 0, 0, 0), "R10");
      wr(0, 32'h8000_0001, "R10");
      wr(4, mk_a(1, 0, 0, 0), "R10");
      wr(0, 32'd5, "R10");
      wr(4, mk_a(1, 1, 0, 0), "R10");
      // R12 write vs strobe
      wr(4, mk_a(0, 0, 1, 1), "R12");
      wr(5, mk_b(1, 1), "R12");
      step(1, 1, 32'hABCD_0000, 1, 32'd3, 0, 0, "R12");
      step(1, 2, 32'h0000_0042, 1, 32'd2, 0, 0, "R12");
      // R11 back to inactive
      wr(4, 32'd0, "R11");
      wr(5, 32'd0, "R11");
      wr(5, 32'h0100_0000, "R11");
      wr(5, 32'd0, "R11");
      @(negedge clk);
      wr_en = 1'b0; upd_valid = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL scoreboard actual=%0d expected=0", sb.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule